// File: doc/BRIEF.md
# Palette and Frame Load Sequencer

This block stands between a stream of 32-bit words coming from a memory fetch engine and the pixel pipeline of a display controller. At every frame boundary it decides whether the words now arriving are colour-table entries, pixel data, or a colour table followed by pixel data. While a colour table is arriving it splits each word into two table entries and writes them to the table through a write port. It also picks up the pixel-depth code carried in the first entry and uses it to decide how long the table is. While pixel data is arriving it hands one word to the pipeline for each pixel request from the timing side.

The block keeps three sticky status bits: table loaded, pixel underflow and frame-sync lost. Each bit can raise the interrupt line when its enable is set. Dropping the enable returns the block to its idle state and clears all status. The fetch engine itself and the timing generator are outside the block. The timing side supplies the frame-start pulse and the pixel requests.

Top module: `ldseq_top`

## Requirements
- R1: `ctrl_mode` selects the fetch: 2'b00 colour table then pixel data, 2'b01 colour table only, 2'b10 and 2'b11 pixel data only. No word is accepted (`in_ready` low) while enabled until a `frame_start` pulse has been seen.
- R2: In a table phase each accepted word holds two entries, the low half first. In the next cycle `pal_we` is high, `pal_addr` holds the even entry index 2k, `pal_even` holds word bits [11:0] and `pal_odd` holds word bits [27:16].
- R3: Bits [15:12] of the first table word are the depth code, and `depth_code` shows it from the next cycle on. Codes 0 to 3 mean a 256-entry table (128 words). Any other code means a 16-entry table (8 words).
- R4: `status[0]` (table loaded) goes high in the cycle after the last table word is accepted.
- R5: Writing `stat_wr` with `stat_wdata[0]`=0 clears `status[0]` only in mode 2'b01. In any other mode the write has no effect.
- R6: In the pixel phase `in_ready` follows `pix_req`. `pix_valid` is high exactly when a word is taken, and `pix_data` equals the input word.
- R7: `status[1]` (underflow) goes high in the cycle after a pixel request in the pixel phase that finds `in_valid` low. Status writes never clear it.
- R8: A `frame_start` during a table phase sets `status[2]` (sync lost) one cycle later and restarts the table at entry 0. `in_ready` is low in that cycle. Status writes never clear this bit.
- R9: While `ctrl_en` is low `in_ready` is low. From the next cycle all status bits read 0, and the block again waits for `frame_start`.
- R10: `irq` is high whenever any status bit is set and its enable in `irq_en` (same bit position) is also set.
- R11: In mode 2'b00 each `frame_start` in the pixel phase starts a new table load. In pixel-only modes a `frame_start` keeps the pixel phase.
- R12: In mode 2'b01, once the table is complete, no further word is accepted until the block is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ctrl_en | input | 1 | Sequencer enable |
| ctrl_mode | input | 2 | Load mode select |
| irq_en | input | 3 | Interrupt enables, one per status bit |
| frame_start | input | 1 | Frame boundary pulse from timing side |
| pix_req | input | 1 | Pixel word request from timing side |
| in_word | input | 32 | Input word stream data |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word accepted when high with valid |
| pal_we | output | 1 | Colour-table write strobe (two entries) |
| pal_addr | output | 8 | Even entry index of the write |
| pal_even | output | 12 | Colour of the even entry |
| pal_odd | output | 12 | Colour of the odd entry |
| depth_code | output | 4 | Depth code taken from the first table word |
| pix_valid | output | 1 | Pixel word handed to the pipeline |
| pix_data | output | 32 | Pixel word |
| stat_wr | input | 1 | Status write strobe |
| stat_wdata | input | 3 | Status write data, zero clears where allowed |
| status | output | 3 | Sticky status: [0] loaded, [1] underflow, [2] sync lost |
| irq | output | 1 | Interrupt request |

## Verification
A behavioural model follows the mode, the entry count and the sticky bits, and the bench compares it with every output at every clock. Colour tables are streamed with both a long depth code and a short one, with and without valid gaps. This separates a table length taken from the first word from a fixed length, and shows whether the word counter stalls correctly on gaps. Pixel phases are run with request and valid patterns that are out of step, so handshakes that take a word are told apart from requests that underflow. Frame pulses arrive in the middle of a table, after a table, in table-only mode and in pixel-only modes, which tells the restart, reload and hold behaviour apart. Status clears are written in table-only and table-then-pixel modes, so the mode-dependent clear rule is tested in both.

// File: rtl/ldseq_pkg.sv
package ldseq_pkg;

    localparam int LD_WORD_W        = 32;
    localparam int LD_COLOR_W       = 12;
    localparam int LD_CODE_W        = 4;
    localparam int LD_FULL_ENTRIES  = 256;
    localparam int LD_SMALL_ENTRIES = 16;
    localparam int LD_FULL_CODE_MAX = 3;
    localparam int LD_STAT_W        = 3;

    // Status bits that software may clear by writing zero (loaded flag only).
    localparam logic [LD_STAT_W-1:0] LD_SW_CLR_MASK = 3'b001;

    typedef enum logic [1:0] {
        LM_PAL_FRAME  = 2'b00,
        LM_PAL_ONLY   = 2'b01,
        LM_FRAME_ONLY = 2'b10,
        LM_FRAME_ALT  = 2'b11
    } load_mode_e;

    typedef enum logic [1:0] {
        ST_WAIT  = 2'd0,
        ST_PAL   = 2'd1,
        ST_FRAME = 2'd2,
        ST_HOLD  = 2'd3
    } seq_state_e;

    typedef struct packed {
        logic sync_lost;
        logic underflow;
        logic pal_loaded;
    } seq_status_t;

    function automatic logic uses_full_table(input logic [LD_CODE_W-1:0] code);
        return code <= LD_CODE_W'(LD_FULL_CODE_MAX);
    endfunction

    function automatic logic mode_has_table(input load_mode_e m);
        return (m == LM_PAL_FRAME) || (m == LM_PAL_ONLY);
    endfunction

endpackage

// File: rtl/ldseq_pal_loader.sv
module ldseq_pal_loader
    import ldseq_pkg::*;
#(
    parameter int COLOR_W       = LD_COLOR_W,
    parameter int FULL_ENTRIES  = LD_FULL_ENTRIES,
    parameter int SMALL_ENTRIES = LD_SMALL_ENTRIES,
    parameter int PAL_AW        = $clog2(FULL_ENTRIES)
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          restart,
    input  logic                          accept,
    input  logic [COLOR_W+LD_CODE_W-1:0]  entry_even,
    input  logic [COLOR_W-1:0]            entry_odd,
    output logic                          last_word,
    output logic                          pal_we,
    output logic [PAL_AW-1:0]             pal_addr,
    output logic [COLOR_W-1:0]            pal_even,
    output logic [COLOR_W-1:0]            pal_odd,
    output logic [LD_CODE_W-1:0]          depth_code
);

    localparam int WC_W       = PAL_AW - 1;
    localparam int FULL_LAST  = FULL_ENTRIES / 2 - 1;
    localparam int SMALL_LAST = SMALL_ENTRIES / 2 - 1;

    logic [WC_W-1:0]      wcnt;
    logic [LD_CODE_W-1:0] code_q;
    logic [LD_CODE_W-1:0] code_now;
    logic [WC_W-1:0]      last_idx;
    logic                 first_word;

    assign first_word = (wcnt == '0);
    assign code_now   = first_word ? entry_even[COLOR_W +: LD_CODE_W] : code_q;
    assign last_idx   = uses_full_table(code_now) ? WC_W'(FULL_LAST) : WC_W'(SMALL_LAST);
    assign last_word  = accept && (wcnt == last_idx);
    assign depth_code = code_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            wcnt     <= '0;
            code_q   <= '0;
            pal_we   <= 1'b0;
            pal_addr <= '0;
            pal_even <= '0;
            pal_odd  <= '0;
        end else begin
            pal_we <= accept;
            if (accept) begin
                pal_addr <= {wcnt, 1'b0};
                pal_even <= entry_even[COLOR_W-1:0];
                pal_odd  <= entry_odd;
                if (first_word) begin
                    code_q <= entry_even[COLOR_W +: LD_CODE_W];
                end
            end
            if (restart || last_word) begin
                wcnt <= '0;
            end else if (accept) begin
                wcnt <= wcnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/ldseq_frame_gate.sv
module ldseq_frame_gate #(
    parameter int WORD_W = 32
) (
    input  logic              active,
    input  logic              pix_req,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_word,
    output logic              take,
    output logic              pix_valid,
    output logic [WORD_W-1:0] pix_data,
    output logic              underflow_evt
);

    assign take          = active & pix_req;
    assign pix_valid     = take & in_valid;
    assign underflow_evt = take & ~in_valid;
    assign pix_data      = in_word;

endmodule

// File: rtl/ldseq_status.sv
module ldseq_status
    import ldseq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en,
    input  logic                 wr,
    input  logic [LD_STAT_W-1:0] wdata,
    input  logic                 clr_allowed,
    input  seq_status_t          set_evt,
    input  logic [LD_STAT_W-1:0] irq_en,
    output logic [LD_STAT_W-1:0] stat,
    output logic                 irq
);

    logic [LD_STAT_W-1:0] set_v;
    logic [LD_STAT_W-1:0] clr_v;

    assign set_v = set_evt;
    assign clr_v = (wr ? ~wdata : '0) & LD_SW_CLR_MASK & {LD_STAT_W{clr_allowed}};

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            stat <= '0;
        end else begin
            stat <= set_v | (stat & ~clr_v);
        end
    end

    assign irq = |(stat & irq_en);

endmodule

// File: rtl/ldseq_top.sv
module ldseq_top
    import ldseq_pkg::*;
#(
    parameter int WORD_W        = LD_WORD_W,
    parameter int COLOR_W       = LD_COLOR_W,
    parameter int FULL_ENTRIES  = LD_FULL_ENTRIES,
    parameter int SMALL_ENTRIES = LD_SMALL_ENTRIES,
    parameter int PAL_AW        = $clog2(FULL_ENTRIES)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 ctrl_en,
    input  logic [1:0]           ctrl_mode,
    input  logic [LD_STAT_W-1:0] irq_en,
    input  logic                 frame_start,
    input  logic                 pix_req,
    input  logic [WORD_W-1:0]    in_word,
    input  logic                 in_valid,
    output logic                 in_ready,
    output logic                 pal_we,
    output logic [PAL_AW-1:0]    pal_addr,
    output logic [COLOR_W-1:0]   pal_even,
    output logic [COLOR_W-1:0]   pal_odd,
    output logic [LD_CODE_W-1:0] depth_code,
    output logic                 pix_valid,
    output logic [WORD_W-1:0]    pix_data,
    input  logic                 stat_wr,
    input  logic [LD_STAT_W-1:0] stat_wdata,
    output logic [LD_STAT_W-1:0] status,
    output logic                 irq
);

    localparam int HALF_W = WORD_W / 2;

    load_mode_e  mode;
    seq_state_e  st, st_n;
    seq_status_t set_evt;

    logic pal_phase, frame_phase;
    logic pal_take, pal_accept, restart, last_word;
    logic fg_take, uf_evt;

    assign mode        = load_mode_e'(ctrl_mode);
    assign pal_phase   = ctrl_en && (st == ST_PAL);
    assign frame_phase = ctrl_en && (st == ST_FRAME);
    assign pal_take    = pal_phase && !frame_start;
    assign pal_accept  = pal_take && in_valid;
    assign restart     = !pal_phase || frame_start;
    assign in_ready    = pal_take || fg_take;

    ldseq_pal_loader #(
        .COLOR_W       (COLOR_W),
        .FULL_ENTRIES  (FULL_ENTRIES),
        .SMALL_ENTRIES (SMALL_ENTRIES),
        .PAL_AW        (PAL_AW)
    ) u_loader (
        .clk        (clk),
        .rst        (rst),
        .restart    (restart),
        .accept     (pal_accept),
        .entry_even (in_word[COLOR_W+LD_CODE_W-1:0]),
        .entry_odd  (in_word[HALF_W+COLOR_W-1:HALF_W]),
        .last_word  (last_word),
        .pal_we     (pal_we),
        .pal_addr   (pal_addr),
        .pal_even   (pal_even),
        .pal_odd    (pal_odd),
        .depth_code (depth_code)
    );

    ldseq_frame_gate #(
        .WORD_W (WORD_W)
    ) u_gate (
        .active        (frame_phase),
        .pix_req       (pix_req),
        .in_valid      (in_valid),
        .in_word       (in_word),
        .take          (fg_take),
        .pix_valid     (pix_valid),
        .pix_data      (pix_data),
        .underflow_evt (uf_evt)
    );

    always_comb begin
        set_evt.pal_loaded = last_word;
        set_evt.underflow  = uf_evt;
        set_evt.sync_lost  = pal_phase && frame_start;
    end

    ldseq_status u_status (
        .clk         (clk),
        .rst         (rst),
        .en          (ctrl_en),
        .wr          (stat_wr),
        .wdata       (stat_wdata),
        .clr_allowed (mode == LM_PAL_ONLY),
        .set_evt     (set_evt),
        .irq_en      (irq_en),
        .stat        (status),
        .irq         (irq)
    );

    always_comb begin
        st_n = st;
        unique case (st)
            ST_WAIT: begin
                if (frame_start) begin
                    st_n = mode_has_table(mode) ? ST_PAL : ST_FRAME;
                end
            end
            ST_PAL: begin
                if (!frame_start && last_word) begin
                    st_n = (mode == LM_PAL_ONLY) ? ST_HOLD : ST_FRAME;
                end
            end
            ST_FRAME: begin
                if (frame_start && (mode == LM_PAL_FRAME)) begin
                    st_n = ST_PAL;
                end
            end
            default: st_n = ST_HOLD;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || !ctrl_en) begin
            st <= ST_WAIT;
        end else begin
            st <= st_n;
        end
    end

endmodule

// File: rtl/ldseq_checker.sv
module ldseq_checker (
    input logic       clk,
    input logic       rst,
    input logic       ctrl_en,
    input logic       in_valid,
    input logic       in_ready,
    input logic       pix_req,
    input logic       pix_valid,
    input logic       pal_we,
    input logic [2:0] status,
    input logic       irq
);

    assert_ready_gated_R9: assert property (@(posedge clk) disable iff (rst)
        !ctrl_en |-> !in_ready);

    assert_status_cleared_R9: assert property (@(posedge clk) disable iff (rst)
        !ctrl_en |=> (status == 3'b000));

    assert_pal_write_source_R2: assert property (@(posedge clk) disable iff (rst)
        pal_we |-> $past(in_valid && in_ready));

    assert_pix_handshake_R6: assert property (@(posedge clk) disable iff (rst)
        pix_valid |-> (in_valid && in_ready && pix_req));

    assert_underflow_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        (ctrl_en && status[1]) |=> status[1]);

    assert_sync_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        (ctrl_en && status[2]) |=> status[2]);

    assert_irq_source_R10: assert property (@(posedge clk) disable iff (rst)
        irq |-> (status != 3'b000));

endmodule

bind ldseq_top ldseq_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .ctrl_en   (ctrl_en),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .pix_req   (pix_req),
    .pix_valid (pix_valid),
    .pal_we    (pal_we),
    .status    (status),
    .irq       (irq)
);

// File: tb/sim_ldseq_top.sv
`timescale 1ns/1ps
module sim_ldseq_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ctrl_en = 1'b0;
    logic [1:0]  ctrl_mode = 2'b00;
    logic [2:0]  irq_en = 3'b000;
    logic        frame_start = 1'b0;
    logic        pix_req = 1'b0;
    logic [31:0] in_word = 32'h0;
    logic        in_valid = 1'b0;
    logic        stat_wr = 1'b0;
    logic [2:0]  stat_wdata = 3'b111;

    logic        in_ready, pal_we, pix_valid, irq;
    logic [7:0]  pal_addr;
    logic [11:0] pal_even, pal_odd;
    logic [3:0]  depth_code;
    logic [31:0] pix_data;
    logic [2:0]  status;

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 0;

    // behavioural model state: 0 wait, 1 table, 2 pixels, 3 table held
    int          m_st = 0;
    int          m_wc = 0;
    logic [3:0]  m_code = 4'h0;
    logic [2:0]  m_stat = 3'b000;
    logic        m_pwe = 1'b0;
    logic [7:0]  m_paddr = 8'h0;
    logic [11:0] m_even = 12'h0, m_odd = 12'h0;
    bit          m_acc = 0;

    always #2.5 clk = ~clk;

    ldseq_top u0 (
        .clk(clk), .rst(rst), .ctrl_en(ctrl_en), .ctrl_mode(ctrl_mode),
        .irq_en(irq_en), .frame_start(frame_start), .pix_req(pix_req),
        .in_word(in_word), .in_valid(in_valid), .in_ready(in_ready),
        .pal_we(pal_we), .pal_addr(pal_addr), .pal_even(pal_even),
        .pal_odd(pal_odd), .depth_code(depth_code), .pix_valid(pix_valid),
        .pix_data(pix_data), .stat_wr(stat_wr), .stat_wdata(stat_wdata),
        .status(status), .irq(irq)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0h expected %0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] wgen(input int i, input int seed);
        logic [31:0] v;
        v = 32'(i + seed + 1) * 32'h9E37_79B1;
        return v ^ (v >> 13);
    endfunction

    task automatic compare_and_step();
        bit exp_ready, exp_pv, last, set1, set2, clr0;
        logic [3:0] code_now;
        int words;
        exp_ready = ctrl_en && ((m_st == 1 && !frame_start) || (m_st == 2 && pix_req));
        exp_pv    = ctrl_en && m_st == 2 && pix_req && in_valid;
        chk("R1", "in_ready", {31'b0, in_ready}, {31'b0, exp_ready});
        chk("R6", "pix_valid", {31'b0, pix_valid}, {31'b0, exp_pv});
        if (exp_pv) chk("R6", "pix_data", pix_data, in_word);
        chk("R2", "pal_we", {31'b0, pal_we}, {31'b0, m_pwe});
        if (m_pwe) begin
            chk("R2", "pal_addr", {24'b0, pal_addr}, {24'b0, m_paddr});
            chk("R2", "pal_even", {20'b0, pal_even}, {20'b0, m_even});
            chk("R2", "pal_odd", {20'b0, pal_odd}, {20'b0, m_odd});
        end
        chk("R3", "depth_code", {28'b0, depth_code}, {28'b0, m_code});
        chk("R4", "status[0]", {31'b0, status[0]}, {31'b0, m_stat[0]});
        chk("R7", "status[1]", {31'b0, status[1]}, {31'b0, m_stat[1]});
        chk("R8", "status[2]", {31'b0, status[2]}, {31'b0, m_stat[2]});
        chk("R10", "irq", {31'b0, irq}, {31'b0, |(m_stat & irq_en)});

        // next model state for the coming clock edge
        m_acc = in_valid && exp_ready;
        if (rst) begin
            m_st = 0; m_wc = 0; m_code = 4'h0; m_stat = 3'b000; m_pwe = 1'b0;
            m_paddr = 8'h0; m_even = 12'h0; m_odd = 12'h0; m_acc = 0;
        end else begin
            m_pwe = m_acc && m_st == 1;
            code_now = (m_wc == 0) ? in_word[15:12] : m_code;
            words = (code_now <= 4'd3) ? 128 : 8;
            last = m_pwe && (m_wc == words - 1);
            if (m_pwe) begin
                m_paddr = 8'(m_wc * 2);
                m_even  = in_word[11:0];
                m_odd   = in_word[27:16];
                if (m_wc == 0) m_code = in_word[15:12];
            end
            if (!ctrl_en) begin
                m_st = 0; m_wc = 0; m_stat = 3'b000;
            end else begin
                set1 = (m_st == 2) && pix_req && !in_valid;
                set2 = (m_st == 1) && frame_start;
                clr0 = stat_wr && !stat_wdata[0] && ctrl_mode == 2'b01;
                m_stat[0] = last || (m_stat[0] && !clr0);
                m_stat[1] = m_stat[1] || set1;
                m_stat[2] = m_stat[2] || set2;
                case (m_st)
                    0: if (frame_start) m_st = (ctrl_mode[1] == 1'b0) ? 1 : 2;
                    1: begin
                        if (frame_start) m_wc = 0;
                        else if (last) begin
                            m_wc = 0;
                            m_st = (ctrl_mode == 2'b01) ? 3 : 2;
                        end else if (m_pwe) m_wc++;
                    end
                    2: if (frame_start && ctrl_mode == 2'b00) m_st = 1;
                    default: ;
                endcase
            end
        end
    endtask

    task automatic tick();
        #1;
        compare_and_step();
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic pulse_frame();
        frame_start = 1'b1;
        tick();
        frame_start = 1'b0;
    endtask

    // stream table words until nwords accepted; first word carries the depth code
    task automatic pal_stream(input logic [3:0] code, input int nwords, input int seed, input bit gaps);
        int idx = 0;
        int guard = 0;
        logic [31:0] w;
        while (idx < nwords && guard < 2000) begin
            w = wgen(idx, seed);
            if (idx == 0) w[15:12] = code;
            in_word  = w;
            in_valid = gaps ? ((guard % 4) != 3) : 1'b1;
            tick();
            if (m_acc) idx++;
            guard++;
        end
        in_valid = 1'b0;
    endtask

    task automatic pixels(input int n, input int seed);
        for (int i = 0; i < n; i++) begin
            in_word  = wgen(i, seed);
            pix_req  = ((i % 3) != 1);
            in_valid = ((i % 5) != 4);
            tick();
        end
        pix_req  = 1'b0;
        in_valid = 1'b0;
    endtask

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        idle(2);                       // reset state checks (R9)
        rst = 1'b0;
        idle(2);

        // R1 R12 R5: table only, short table (code 4), with gaps
        ctrl_mode = 2'b01; irq_en = 3'b001; ctrl_en = 1'b1;
        in_valid = 1'b1; in_word = 32'hDEAD_BEEF;
        idle(3);                       // no frame_start yet: nothing taken (R1)
        in_valid = 1'b0;
        pulse_frame();
        pal_stream(4'h4, 8, 10, 1);
        in_valid = 1'b1;
        idle(4);                       // held: R12
        in_valid = 1'b0;
        stat_wr = 1'b1; stat_wdata = 3'b110;  // clear loaded bit (R5)
        tick();
        stat_wr = 1'b0; stat_wdata = 3'b111;
        idle(2);
        ctrl_en = 1'b0;                // R9
        idle(3);

        // R11 R7 R5: table then pixels, long table (code 2)
        ctrl_mode = 2'b00; irq_en = 3'b010; ctrl_en = 1'b1;
        pulse_frame();
        pal_stream(4'h2, 128, 40, 1);
        pixels(30, 7);
        stat_wr = 1'b1; stat_wdata = 3'b000;  // must have no effect in this mode
        tick();
        stat_wr = 1'b0; stat_wdata = 3'b111;
        idle(2);
        pulse_frame();                 // new frame reloads table (R11)
        pal_stream(4'hB, 8, 90, 0);
        pixels(12, 3);

        // R8: frame pulse in the middle of a table load
        irq_en = 3'b100;
        pulse_frame();
        pal_stream(4'h1, 3, 55, 0);
        pulse_frame();
        pal_stream(4'h5, 8, 66, 1);
        pixels(6, 11);
        ctrl_en = 1'b0;
        idle(2);

        // R1 R11: pixel-only modes stay in pixel phase across frames
        ctrl_mode = 2'b10; irq_en = 3'b111; ctrl_en = 1'b1;
        pulse_frame();
        pixels(15, 21);
        pulse_frame();
        pixels(10, 22);
        ctrl_en = 1'b0;
        idle(2);
        ctrl_mode = 2'b11; ctrl_en = 1'b1;
        pixels(4, 30);                 // before frame_start nothing taken
        pulse_frame();
        pixels(10, 31);
        ctrl_en = 1'b0;
        idle(3);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule